// File: doc/BRIEF.md
# DMA Register and Interrupt Block

This block is the register front end of a multi-channel DMA controller. A 4 KB slave window, addressed in 32-bit words, gives software access to a small set of global registers, to five 32-bit registers per channel, and to eight read-only identification words at the top of the window. A transfer engine outside this block reads each channel's registers from dedicated output buses. It reports completion and failure through one-cycle terminal-count and error pulses for each channel.

The block keeps a raw terminal-count bit and a raw error bit for each channel. Each raw bit is masked by an enable bit held in that channel's own configuration word. A single interrupt line goes high whenever any masked bit is set. Software clears raw bits by writing ones to the two clear words. The channel count is a parameter, either 2 or 8, and the first identification byte depends on it. Read data is combinational from the word address. A write takes effect on the clock edge at which `we_i` is high.

Top module: `dma_regfile`

## Requirements
- R1: After reset every channel register, the global configuration and all raw interrupt bits are zero, `irq_o` is low, and every status word reads zero.
- R2: Channel n's registers are at byte offset 0x100 + 0x20·n: source (+0x00), destination (+0x04), link (+0x08), control (+0x0C), configuration (+0x10). Each stores a full 32-bit write, reads it back, and drives it on that channel's slice of the matching output bus.
- R3: A channel window whose index is at or above the channel count reads zero and ignores writes. Offsets +0x14 to +0x1C inside any channel window also read zero.
- R4: A terminal-count pulse on channel n sets bit n of the raw TC word (byte 0x014). An error pulse sets bit n of the raw error word (byte 0x018). Each bit stays set until it is cleared.
- R5: A write to byte 0x008 clears every raw TC bit where the write data has a 1. A write to byte 0x010 does the same for the raw error bits.
- R6: When a pulse and a clear hit the same raw bit in the same cycle, the bit is set afterwards.
- R7: Channel n's TC mask is bit 15 of its configuration word and its error mask is bit 14. Byte 0x004 reads raw TC AND TC mask, byte 0x00C reads raw error AND error mask, and byte 0x000 reads the OR of the two.
- R8: `irq_o` is high exactly when the combined masked status at byte 0x000 is nonzero.
- R9: Bit n of byte 0x01C is bit 0 of channel n's configuration word.
- R10: Byte 0x030 holds a 3-bit global configuration. Bit 0 enables the controller and bits 1 and 2 select the master byte orders. The upper bits read zero. The value drives `gcfg_o`.
- R11: Bytes 0xFE0 to 0xFFC read one identification byte each, in the low 8 bits: 80,10,04,0A,0D,F0,05,B1 (hex) for 8 channels. The first byte is 81 for 2 channels.
- R12: Every other offset reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the addressed word |
| waddr_i | input | 10 | Word address (byte offset bits 11:2) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `waddr_i`, combinational |
| tc_pulse_i | input | NUM_CH | Terminal-count event per channel |
| err_pulse_i | input | NUM_CH | Error event per channel |
| ch_src_o | output | NUM_CH·32 | Source address of each channel |
| ch_dst_o | output | NUM_CH·32 | Destination address of each channel |
| ch_lli_o | output | NUM_CH·32 | Link pointer of each channel |
| ch_ctrl_o | output | NUM_CH·32 | Control word of each channel |
| ch_conf_o | output | NUM_CH·32 | Configuration word of each channel |
| gcfg_o | output | 3 | Global configuration: enable and byte orders |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that `we_i`, `waddr_i`, `wdata_i` and the event pulses are stable around each rising edge, and that a write is a single-cycle strobe with no handshake. The bench keeps to this by changing every input only on the falling edge. It runs with two channels, so that the unimplemented channel windows can be exercised. Its random phase draws addresses from a list of legal, unimplemented and undefined offsets, and fires pulses in the same cycles as clear writes.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned WADDR_W = 10;

  typedef enum logic [2:0] {
    CR_SRC  = 3'd0,
    CR_DST  = 3'd1,
    CR_LLI  = 3'd2,
    CR_CTRL = 3'd3,
    CR_CONF = 3'd4
  } chan_reg_e;

  // global word indices inside the first 256 bytes
  localparam logic [5:0] GW_STAT    = 6'd0;
  localparam logic [5:0] GW_TCSTAT  = 6'd1;
  localparam logic [5:0] GW_TCCLR   = 6'd2;
  localparam logic [5:0] GW_ERRSTAT = 6'd3;
  localparam logic [5:0] GW_ERRCLR  = 6'd4;
  localparam logic [5:0] GW_TCRAW   = 6'd5;
  localparam logic [5:0] GW_ERRRAW  = 6'd6;
  localparam logic [5:0] GW_ENBL    = 6'd7;
  localparam logic [5:0] GW_CFG     = 6'd12;

  localparam int unsigned CONF_EN_BIT   = 0;
  localparam int unsigned CONF_ERRM_BIT = 14;
  localparam int unsigned CONF_TCM_BIT  = 15;
  localparam int unsigned GCFG_W        = 3;

  typedef struct packed {
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] dst;
    logic [DATA_W-1:0] lli;
    logic [DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] conf;
  } chan_regs_t;

  function automatic logic [7:0] id_byte(input int unsigned nch, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = (nch == 8) ? 8'h80 : 8'h81;
      3'd1:    b = 8'h10;
      3'd2:    b = 8'h04;
      3'd3:    b = 8'h0A;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output chan_regs_t        regs_o,
  output logic [DATA_W-1:0] rdata_o
);
  chan_regs_t regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_i) begin
      case (chan_reg_e'(reg_i))
        CR_SRC:  regs_q.src  <= wdata_i;
        CR_DST:  regs_q.dst  <= wdata_i;
        CR_LLI:  regs_q.lli  <= wdata_i;
        CR_CTRL: regs_q.ctrl <= wdata_i;
        CR_CONF: regs_q.conf <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (chan_reg_e'(reg_i))
      CR_SRC:  rdata_o = regs_q.src;
      CR_DST:  rdata_o = regs_q.dst;
      CR_LLI:  rdata_o = regs_q.lli;
      CR_CTRL: rdata_o = regs_q.ctrl;
      CR_CONF: rdata_o = regs_q.conf;
      default: rdata_o = '0;
    endcase
  end

  assign regs_o = regs_q;

  // R2
  wr_conf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_i == CR_CONF) |=> (regs_q.conf == $past(wdata_i)));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(regs_q));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tc_pulse_i,
  input  logic [NUM_CH-1:0] err_pulse_i,
  input  logic [NUM_CH-1:0] tc_clr_i,
  input  logic [NUM_CH-1:0] err_clr_i,
  input  logic [NUM_CH-1:0] tc_mask_i,
  input  logic [NUM_CH-1:0] err_mask_i,
  output logic [NUM_CH-1:0] tc_raw_o,
  output logic [NUM_CH-1:0] err_raw_o,
  output logic [NUM_CH-1:0] tc_stat_o,
  output logic [NUM_CH-1:0] err_stat_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] tc_raw_q, err_raw_q;

  // set wins over clear so a same-cycle event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_raw_q  <= '0;
      err_raw_q <= '0;
    end else begin
      tc_raw_q  <= (tc_raw_q  & ~tc_clr_i)  | tc_pulse_i;
      err_raw_q <= (err_raw_q & ~err_clr_i) | err_pulse_i;
    end
  end

  assign tc_raw_o   = tc_raw_q;
  assign err_raw_o  = err_raw_q;
  assign tc_stat_o  = tc_raw_q  & tc_mask_i;
  assign err_stat_o = err_raw_q & err_mask_i;
  assign irq_o      = |{tc_stat_o, err_stat_o};

  // R4
  tc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_pulse_i != '0) |=> ((tc_raw_q & $past(tc_pulse_i)) == $past(tc_pulse_i)));

  // R5
  tc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_clr_i != '0) |=> ((tc_raw_q & $past(tc_clr_i & ~tc_pulse_i)) == '0));

  // R5
  err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i != '0) |=> ((err_raw_q & $past(err_clr_i & ~err_pulse_i)) == '0));

  // R4
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((err_raw_q & ~$past(err_raw_q) & ~$past(err_pulse_i)) == '0));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_reg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [WADDR_W-1:0]       waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [NUM_CH-1:0]        tc_pulse_i,
  input  logic [NUM_CH-1:0]        err_pulse_i,
  output logic [NUM_CH*DATA_W-1:0] ch_src_o,
  output logic [NUM_CH*DATA_W-1:0] ch_dst_o,
  output logic [NUM_CH*DATA_W-1:0] ch_lli_o,
  output logic [NUM_CH*DATA_W-1:0] ch_ctrl_o,
  output logic [NUM_CH*DATA_W-1:0] ch_conf_o,
  output logic [GCFG_W-1:0]        gcfg_o,
  output logic                     irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_CH;

  // address decode: byte offset bits 11:2
  logic       in_glob, in_chan, in_id;
  logic [5:0] g_idx;
  logic [2:0] ch_idx, ch_reg;

  assign in_glob = (waddr_i[9:6] == 4'h0);
  assign in_chan = (waddr_i[9:6] == 4'h1);
  assign in_id   = (waddr_i[9:3] == 7'h7F);
  assign g_idx   = waddr_i[5:0];
  assign ch_idx  = waddr_i[5:3];
  assign ch_reg  = waddr_i[2:0];

  chan_regs_t        ch_regs [NUM_CH];
  logic [DATA_W-1:0] ch_rd   [NUM_CH];
  logic [NUM_CH-1:0] ch_wr, tc_mask, err_mask, ch_en;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_wr[c] = we_i && in_chan && (ch_idx == 3'(c));

    dma_chan_regs u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (ch_wr[c]),
      .reg_i   (ch_reg),
      .wdata_i (wdata_i),
      .regs_o  (ch_regs[c]),
      .rdata_o (ch_rd[c])
    );

    assign ch_src_o [c*DATA_W +: DATA_W] = ch_regs[c].src;
    assign ch_dst_o [c*DATA_W +: DATA_W] = ch_regs[c].dst;
    assign ch_lli_o [c*DATA_W +: DATA_W] = ch_regs[c].lli;
    assign ch_ctrl_o[c*DATA_W +: DATA_W] = ch_regs[c].ctrl;
    assign ch_conf_o[c*DATA_W +: DATA_W] = ch_regs[c].conf;
    assign tc_mask[c]  = ch_regs[c].conf[CONF_TCM_BIT];
    assign err_mask[c] = ch_regs[c].conf[CONF_ERRM_BIT];
    assign ch_en[c]    = ch_regs[c].conf[CONF_EN_BIT];
  end

  // global configuration
  logic [GCFG_W-1:0] gcfg_q;
  logic              gcfg_wr;
  assign gcfg_wr = we_i && in_glob && (g_idx == GW_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gcfg_q <= '0;
    else if (gcfg_wr) gcfg_q <= wdata_i[GCFG_W-1:0];
  end
  assign gcfg_o = gcfg_q;

  // interrupt state
  logic [NUM_CH-1:0] tc_clr, err_clr, tc_raw, err_raw, tc_stat, err_stat;
  assign tc_clr  = (we_i && in_glob && g_idx == GW_TCCLR)  ? wdata_i[NUM_CH-1:0] : '0;
  assign err_clr = (we_i && in_glob && g_idx == GW_ERRCLR) ? wdata_i[NUM_CH-1:0] : '0;

  dma_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tc_pulse_i  (tc_pulse_i),
    .err_pulse_i (err_pulse_i),
    .tc_clr_i    (tc_clr),
    .err_clr_i   (err_clr),
    .tc_mask_i   (tc_mask),
    .err_mask_i  (err_mask),
    .tc_raw_o    (tc_raw),
    .err_raw_o   (err_raw),
    .tc_stat_o   (tc_stat),
    .err_stat_o  (err_stat),
    .irq_o       (irq_o)
  );

  // read mux
  always_comb begin
    rdata_o = '0;
    if (in_id) begin
      rdata_o = {24'h0, id_byte(NUM_CH, waddr_i[2:0])};
    end else if (in_chan) begin
      for (int c = 0; c < NUM_CH; c++)
        if (ch_idx == 3'(c)) rdata_o = ch_rd[c];
    end else if (in_glob) begin
      case (g_idx)
        GW_STAT:    rdata_o = {{PAD_W{1'b0}}, tc_stat | err_stat};
        GW_TCSTAT:  rdata_o = {{PAD_W{1'b0}}, tc_stat};
        GW_ERRSTAT: rdata_o = {{PAD_W{1'b0}}, err_stat};
        GW_TCRAW:   rdata_o = {{PAD_W{1'b0}}, tc_raw};
        GW_ERRRAW:  rdata_o = {{PAD_W{1'b0}}, err_raw};
        GW_ENBL:    rdata_o = {{PAD_W{1'b0}}, ch_en};
        GW_CFG:     rdata_o = {{(DATA_W-GCFG_W){1'b0}}, gcfg_q};
        default:    rdata_o = '0;
      endcase
    end
  end

  // R8
  irq_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waddr_i == '0) |-> (irq_o == (rdata_o != '0)));

  // R10
  gcfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gcfg_wr |=> $stable(gcfg_o));

  // R11
  id_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_id |-> (rdata_o[31:8] == '0));
endmodule

// File: tb/dma_regfile_bench.sv
module dma_regfile_bench;
  localparam int NCH = 2;
  localparam int ADDR_N = 24;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic [9:0]        waddr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NCH-1:0]    tc_pulse_i = '0, err_pulse_i = '0;
  logic [NCH*32-1:0] ch_src_o, ch_dst_o, ch_lli_o, ch_ctrl_o, ch_conf_o;
  logic [2:0]        gcfg_o;
  logic              irq_o;

  always #4 clk_i = ~clk_i;

  dma_regfile #(.NUM_CH(NCH)) u_dma_regfile (
    .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i, .rdata_o,
    .tc_pulse_i, .err_pulse_i,
    .ch_src_o, .ch_dst_o, .ch_lli_o, .ch_ctrl_o, .ch_conf_o,
    .gcfg_o, .irq_o
  );

  // reference model
  logic [31:0]    m_src [NCH], m_dst [NCH], m_lli [NCH], m_ctrl [NCH], m_conf [NCH];
  logic [NCH-1:0] m_tc, m_err;
  logic [2:0]     m_gcfg;
  int vectors = 0, fails = 0;
  bit done = 0;

  function automatic logic [NCH-1:0] tcm();
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = m_conf[c][15];
    return r;
  endfunction
  function automatic logic [NCH-1:0] erm();
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = m_conf[c][14];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    int ch, off;
    logic [NCH-1:0] en;
    logic [7:0] ids [8];
    ids = '{(NCH == 8) ? 8'h80 : 8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    a = a & 'hFFC;
    if (a >= 'hFE0) return 32'(ids[(a - 'hFE0) / 4]);
    if (a >= 'h100 && a < 'h200) begin
      ch = (a - 'h100) / 32; off = (a - 'h100) % 32;
      if (ch >= NCH) return 0;
      case (off)
        0: return m_src[ch];
        4: return m_dst[ch];
        8: return m_lli[ch];
        12: return m_ctrl[ch];
        16: return m_conf[ch];
        default: return 0;
      endcase
    end
    if (a < 'h100) begin
      for (int c = 0; c < NCH; c++) en[c] = m_conf[c][0];
      case (a / 4)
        0: return 32'((m_tc & tcm()) | (m_err & erm()));
        1: return 32'(m_tc & tcm());
        3: return 32'(m_err & erm());
        5: return 32'(m_tc);
        6: return 32'(m_err);
        7: return 32'(en);
        12: return 32'(m_gcfg);
        default: return 0;
      endcase
    end
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_src[c] = 0; m_dst[c] = 0; m_lli[c] = 0; m_ctrl[c] = 0; m_conf[c] = 0;
    end
    m_tc = 0; m_err = 0; m_gcfg = 0;
  endtask

  // one clock: drive at negedge, compare before posedge, update model at posedge
  task automatic cyc(input logic we, input int a, input logic [31:0] d,
                     input logic [NCH-1:0] tp, input logic [NCH-1:0] ep, input string tag);
    int ch, off;
    we_i = we; waddr_i = 10'(a >> 2); wdata_i = d; tc_pulse_i = tp; err_pulse_i = ep;
    #1;
    check(tag, rdata_o, exp_rd(a), $sformatf("read @%03h", a));
    check("R8", 32'(irq_o), 32'(((m_tc & tcm()) | (m_err & erm())) != 0), "irq");
    check("R10", 32'(gcfg_o), 32'(m_gcfg), "gcfg");
    for (int c = 0; c < NCH; c++) begin
      check("R2", ch_src_o[c*32 +: 32], m_src[c], "src bus");
      check("R2", ch_dst_o[c*32 +: 32], m_dst[c], "dst bus");
      check("R2", ch_lli_o[c*32 +: 32], m_lli[c], "lli bus");
      check("R2", ch_ctrl_o[c*32 +: 32], m_ctrl[c], "ctrl bus");
      check("R2", ch_conf_o[c*32 +: 32], m_conf[c], "conf bus");
    end
    @(posedge clk_i);
    if (we) begin
      a = a & 'hFFC;
      if (a >= 'h100 && a < 'h200) begin
        ch = (a - 'h100) / 32; off = (a - 'h100) % 32;
        if (ch < NCH)
          case (off)
            0: m_src[ch] = d;
            4: m_dst[ch] = d;
            8: m_lli[ch] = d;
            12: m_ctrl[ch] = d;
            16: m_conf[ch] = d;
            default: ;
          endcase
      end else if (a == 'h008) m_tc = m_tc & ~d[NCH-1:0];
      else if (a == 'h010) m_err = m_err & ~d[NCH-1:0];
      else if (a == 'h030) m_gcfg = d[2:0];
    end
    m_tc = m_tc | tp;
    m_err = m_err | ep;
    @(negedge clk_i);
  endtask

  task automatic rd(input int a, input string tag);
    cyc(1'b0, a, 32'h0, '0, '0, tag);
  endtask
  task automatic wr(input int a, input logic [31:0] d, input string tag);
    cyc(1'b1, a, d, '0, '0, tag);
  endtask

  int addr_list [ADDR_N] = '{'h000, 'h004, 'h008, 'h00C, 'h010, 'h014, 'h018, 'h01C,
                             'h030, 'h040, 'h100, 'h104, 'h108, 'h10C, 'h110, 'h114,
                             'h120, 'h124, 'h130, 'h140, 'h150, 'h1F0, 'h800, 'hFE4};

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd('h000, "R1"); rd('h014, "R1"); rd('h018, "R1"); rd('h01C, "R1");
    rd('h030, "R1"); rd('h100, "R1"); rd('h110, "R1"); rd('h130, "R1");
    // R2 per-channel storage
    wr('h100, 32'hDEAD_BEEF, "R2"); wr('h104, 32'h1234_5678, "R2");
    wr('h108, 32'hA5A5_0000, "R2"); wr('h10C, 32'h8000_0FFF, "R2");
    wr('h120, 32'h0F0F_F0F0, "R2"); wr('h12C, 32'hFFFF_FFFF, "R2");
    rd('h100, "R2"); rd('h104, "R2"); rd('h108, "R2"); rd('h10C, "R2");
    rd('h120, "R2"); rd('h12C, "R2");
    // R3 unimplemented channels and holes
    wr('h140, 32'h1111_1111, "R3"); wr('h1F0, 32'h2222_2222, "R3");
    rd('h140, "R3"); rd('h1F0, "R3"); rd('h114, "R3"); rd('h11C, "R3");
    rd('h100, "R3");
    // R9 enable bitmap
    wr('h130, 32'h0000_0001, "R9"); rd('h01C, "R9");
    wr('h110, 32'h0000_0001, "R9"); rd('h01C, "R9");
    // R4 raw bits
    cyc(1'b0, 'h014, 0, 2'b01, 2'b00, "R4"); rd('h014, "R4");
    cyc(1'b0, 'h018, 0, 2'b00, 2'b10, "R4"); rd('h018, "R4");
    rd('h000, "R7");
    // R7 masks
    wr('h110, 32'h0000_8001, "R7"); rd('h004, "R7"); rd('h000, "R7");
    wr('h130, 32'h0000_4000, "R7"); rd('h00C, "R7"); rd('h000, "R7");
    // R5 clears
    wr('h008, 32'h0000_0001, "R5"); rd('h014, "R5"); rd('h004, "R5");
    wr('h010, 32'hFFFF_FFFF, "R5"); rd('h018, "R5"); rd('h000, "R8");
    // R6 pulse wins over clear
    cyc(1'b0, 'h014, 0, 2'b11, 2'b11, "R6");
    cyc(1'b1, 'h008, 32'h3, 2'b01, 2'b00, "R6"); rd('h014, "R6");
    cyc(1'b1, 'h010, 32'h3, 2'b00, 2'b10, "R6"); rd('h018, "R6");
    // R10 global configuration
    wr('h030, 32'hFFFF_FFFF, "R10"); rd('h030, "R10");
    wr('h030, 32'h0000_0002, "R10"); rd('h030, "R10");
    // R11 identification
    for (int i = 0; i < 8; i++) rd('hFE0 + 4 * i, "R11");
    // R12 undefined offsets
    wr('h040, 32'hFFFF_FFFF, "R12"); wr('h800, 32'hFFFF_FFFF, "R12");
    wr('h020, 32'hFFFF_FFFF, "R12");
    rd('h008, "R12"); rd('h010, "R12"); rd('h020, "R12"); rd('h040, "R12");
    rd('h200, "R12"); rd('h800, "R12"); rd('hFDC, "R12");
    // mixed traffic, model compared every cycle
    for (int i = 0; i < 600; i++) begin
      int a;
      a = addr_list[$urandom % ADDR_N];
      cyc(1'(($urandom % 3) == 0), a, $urandom, NCH'($urandom % 4 == 0 ? $urandom : 0),
          NCH'($urandom % 5 == 0 ? $urandom : 0), "R7");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule